// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Message Unit

This block joins two processors, called side A and side B, through a shared set of mailbox words and doorbells. Each side owns a small 32-bit register port with write strobe, read strobe, byte address and data. A word that one side writes into its outgoing mailbox slot n shows up in the other side's incoming slot n. A pair of flags per slot tells the writer when the slot is free and tells the reader when fresh data waits. Reading the incoming slot hands it back to the writer.

Next to the data slots there are four doorbells in each direction. A side rings doorbell n by writing a one into a request bit of its control register. That sets a pending flag in the partner's status register, which the partner acknowledges by writing a one to that flag. Each side drives one interrupt line, the OR of its status flags gated by per-flag enables in its own control register.

Either side can start a unit reset by writing control bit 5. A small state machine walks through three states. RUN is normal operation. CLEAR wipes every slot, flag and enable. SETTLE holds the unit busy for `RST_HOLD` further cycles. The transitions are: RUN to CLEAR on a reset request, CLEAR to SETTLE unconditionally, and SETTLE back to RUN when its counter reaches zero. While the unit is busy, status bit 7 and control bit 5 read 1, and bus writes and read side effects are ignored.

Top module: `msgu_top`

## Requirements
- R1: On each side, outgoing slot n is at byte address 4n and incoming slot n at 0x10+4n. Status is at 0x20 and control at 0x24. Reading an outgoing slot or any unmapped address returns 0.
- R2: Writing outgoing slot n clears the writer's empty flag, status bit 23-n. It sets the partner's full flag, status bit 27-n. The partner's incoming slot n then returns the written word.
- R3: Reading incoming slot n clears the reader's full flag n and sets the writer's empty flag n again. Reading an empty slot returns the last word held and changes no flag.
- R4: Writing outgoing slot n while its empty flag is 0 replaces the held word and leaves all flags unchanged.
- R5: Writing 1 to control bit 19-n sets the partner's pending flag, status bit 31-n. The writer's control bit 19-n reads 1 until the partner clears that pending flag, then reads 0.
- R6: Writing 1 to status bit 31-n clears this side's pending flag n. Writing 0 there has no effect.
- R7: A side's interrupt is 1 exactly when some enabled flag is set. The enables sit in control bit 23-n (empty n), bit 27-n (full n) and bit 31-n (pending n). Writing control replaces all enables.
- R8: Writing 1 to control bit 5 makes status bit 7 and control bit 5 read 1 from the next cycle, for RST_HOLD+1 cycles, then 0. Bus writes made during that window are ignored.
- R9: After power-on reset or a unit reset, all empty flags read 1, all full and pending flags read 0, control reads 0 and incoming slots read 0 (status 0x00F00000).
- R10: Both directions behave identically, with side B's registers mirroring side A's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe (read side effects) |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational on a_addr |
| a_irq | output | 1 | Side A interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe (read side effects) |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational on b_addr |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench targets the reversed bit packing by using slots 0 through 3 in different scenarios. A design that packed index 0 at the low bit would report the wrong status words. A second write into a slot that is still full must leave the flags untouched and replace the word; a design that cleared or toggled the flag there would lose track of the occupancy. The doorbell test writes zero and then one to the pending flag, which separates true write-one-to-clear behaviour from plain register writes, and checks that the partner's request bit falls with it. The unit reset test samples the busy bit on the last busy cycle and on the first free cycle, and tries a write inside the window. A state machine with the wrong length, or one that let bus traffic through while busy, shows up there.

// File: rtl/msgu_pkg.sv
package msgu_pkg;
    localparam int NCH      = 4;
    localparam int OFS_TX   = 'h00;
    localparam int OFS_RX   = 'h10;
    localparam int OFS_STAT = 'h20;
    localparam int OFS_CTRL = 'h24;
    localparam int BIT_RST  = 5;
    localparam int BIT_BUSY = 7;
    localparam int GRP_REQ  = 16;
    localparam int GRP_TE   = 20;
    localparam int GRP_RF   = 24;
    localparam int GRP_GP   = 28;

    typedef enum logic [1:0] {
        UR_RUN    = 2'd0,
        UR_CLEAR  = 2'd1,
        UR_SETTLE = 2'd2
    } urst_state_t;

    // index 0 lands on the highest bit of a group
    function automatic logic [NCH-1:0] flip(input logic [NCH-1:0] v);
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) r[i] = v[NCH-1-i];
        return r;
    endfunction
endpackage

// File: rtl/msgu_lane.sv
module msgu_lane #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic          ring,
    input  logic          ack,
    output logic [DW-1:0] word,
    output logic          full,
    output logic          pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            full <= 1'b0;
            pend <= 1'b0;
        end else if (clr) begin
            word <= '0;
            full <= 1'b0;
            pend <= 1'b0;
        end else begin
            if (wr) begin
                word <= wdata;
                full <= 1'b1;
            end else if (rd) begin
                full <= 1'b0;
            end
            if (ring)     pend <= 1'b1;
            else if (ack) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/msgu_urst.sv
module msgu_urst #(
    parameter int RST_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic clr,
    output logic busy
);
    import msgu_pkg::*;

    localparam int CW = (RST_HOLD < 2) ? 1 : $clog2(RST_HOLD + 1);

    urst_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UR_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            UR_RUN: begin
                if (req) state_d = UR_CLEAR;
            end
            UR_CLEAR: begin
                state_d = UR_SETTLE;
                cnt_d   = CW'(RST_HOLD - 1);
            end
            UR_SETTLE: begin
                if (cnt_q == '0) state_d = UR_RUN;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = UR_RUN;
        endcase
    end

    always_comb begin
        clr  = (state_q == UR_CLEAR);
        busy = (state_q != UR_RUN);
    end
endmodule

// File: rtl/msgu_port.sv
module msgu_port #(
    parameter int DW  = 32,
    parameter int AW  = 6,
    parameter int NCH = msgu_pkg::NCH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    busy,
    input  logic                    wr,
    input  logic                    rd,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    output logic                    irq,
    input  logic [NCH-1:0]          out_full,
    input  logic [NCH-1:0]          out_pend,
    input  logic [NCH-1:0]          in_full,
    input  logic [NCH-1:0]          in_pend,
    input  logic [NCH-1:0][DW-1:0]  in_word,
    output logic [NCH-1:0]          tx_we,
    output logic [NCH-1:0]          rx_re,
    output logic [NCH-1:0]          ring,
    output logic [NCH-1:0]          ack,
    output logic                    rst_req
);
    import msgu_pkg::*;

    logic [NCH-1:0] en_te, en_rf, en_gp;
    logic           wr_ok, stat_wr, ctrl_wr, cfg_wr;
    logic           unused_wdata;

    assign unused_wdata = ^wdata;
    assign wr_ok   = wr & ~busy;
    assign stat_wr = wr_ok & (addr == AW'(OFS_STAT));
    assign ctrl_wr = wr_ok & (addr == AW'(OFS_CTRL));
    assign rst_req = ctrl_wr &  wdata[BIT_RST];
    assign cfg_wr  = ctrl_wr & ~wdata[BIT_RST];

    for (genvar n = 0; n < NCH; n++) begin : g_dec
        assign tx_we[n] = wr_ok & (addr == AW'(OFS_TX + 4 * n));
        assign rx_re[n] = rd & ~busy & (addr == AW'(OFS_RX + 4 * n));
    end

    assign ring = flip(wdata[GRP_REQ +: NCH]) & {NCH{cfg_wr}};
    assign ack  = flip(wdata[GRP_GP  +: NCH]) & {NCH{stat_wr}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_te <= '0;
            en_rf <= '0;
            en_gp <= '0;
        end else if (clr) begin
            en_te <= '0;
            en_rf <= '0;
            en_gp <= '0;
        end else if (cfg_wr) begin
            en_te <= flip(wdata[GRP_TE +: NCH]);
            en_rf <= flip(wdata[GRP_RF +: NCH]);
            en_gp <= flip(wdata[GRP_GP +: NCH]);
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFS_STAT)) begin
            rdata[GRP_TE +: NCH] = flip(~out_full);
            rdata[GRP_RF +: NCH] = flip(in_full);
            rdata[GRP_GP +: NCH] = flip(in_pend);
            rdata[BIT_BUSY]      = busy;
        end else if (addr == AW'(OFS_CTRL)) begin
            rdata[GRP_REQ +: NCH] = flip(out_pend);
            rdata[GRP_TE  +: NCH] = flip(en_te);
            rdata[GRP_RF  +: NCH] = flip(en_rf);
            rdata[GRP_GP  +: NCH] = flip(en_gp);
            rdata[BIT_RST]        = busy;
        end else begin
            for (int n = 0; n < NCH; n++)
                if (addr == AW'(OFS_RX + 4 * n)) rdata = in_word[n];
        end
    end

    assign irq = |(~out_full & en_te) | |(in_full & en_rf) | |(in_pend & en_gp);
endmodule

// File: rtl/msgu_top.sv
module msgu_top #(
    parameter int DW       = 32,
    parameter int AW       = 6,
    parameter int RST_HOLD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_wr,
    input  logic          a_rd,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_wr,
    input  logic          b_rd,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    import msgu_pkg::*;

    logic clr, busy, a_rst_req, b_rst_req;
    logic [NCH-1:0]         full_ab, full_ba, pend_ab, pend_ba;
    logic [NCH-1:0][DW-1:0] word_ab, word_ba;
    logic [NCH-1:0]         a_tx_we, a_rx_re, a_ring, a_ack;
    logic [NCH-1:0]         b_tx_we, b_rx_re, b_ring, b_ack;

    msgu_urst #(.RST_HOLD(RST_HOLD)) u_urst (
        .clk(clk), .rst_n(rst_n), .req(a_rst_req | b_rst_req),
        .clr(clr), .busy(busy)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_lane
        msgu_lane #(.DW(DW)) u_ab (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .wr(a_tx_we[n]), .wdata(a_wdata), .rd(b_rx_re[n]),
            .ring(a_ring[n]), .ack(b_ack[n]),
            .word(word_ab[n]), .full(full_ab[n]), .pend(pend_ab[n])
        );
        msgu_lane #(.DW(DW)) u_ba (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .wr(b_tx_we[n]), .wdata(b_wdata), .rd(a_rx_re[n]),
            .ring(b_ring[n]), .ack(a_ack[n]),
            .word(word_ba[n]), .full(full_ba[n]), .pend(pend_ba[n])
        );
    end

    msgu_port #(.DW(DW), .AW(AW), .NCH(NCH)) u_pa (
        .clk(clk), .rst_n(rst_n), .clr(clr), .busy(busy),
        .wr(a_wr), .rd(a_rd), .addr(a_addr), .wdata(a_wdata),
        .rdata(a_rdata), .irq(a_irq),
        .out_full(full_ab), .out_pend(pend_ab),
        .in_full(full_ba), .in_pend(pend_ba), .in_word(word_ba),
        .tx_we(a_tx_we), .rx_re(a_rx_re), .ring(a_ring), .ack(a_ack),
        .rst_req(a_rst_req)
    );

    msgu_port #(.DW(DW), .AW(AW), .NCH(NCH)) u_pb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .busy(busy),
        .wr(b_wr), .rd(b_rd), .addr(b_addr), .wdata(b_wdata),
        .rdata(b_rdata), .irq(b_irq),
        .out_full(full_ba), .out_pend(pend_ba),
        .in_full(full_ab), .in_pend(pend_ab), .in_word(word_ab),
        .tx_we(b_tx_we), .rx_re(b_rx_re), .ring(b_ring), .ack(b_ack),
        .rst_req(b_rst_req)
    );
endmodule

// File: rtl/msgu_chk.sv
module msgu_chk #(
    parameter int AW       = 6,
    parameter int RST_HOLD = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          a_wr,
    input logic [AW-1:0] a_addr,
    input logic          a_req0,
    input logic          a_rstbit,
    input logic          b_rd,
    input logic [AW-1:0] b_addr,
    input logic          a_irq,
    input logic [3:0]    full_ab,
    input logic [3:0]    full_ba,
    input logic [3:0]    pend_ab,
    input logic [3:0]    pend_ba
);
    int busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cnt <= 0;
        else if (busy)  busy_cnt <= busy_cnt + 1;
        else            busy_cnt <= 0;
    end

    AST_TX_FILLS_PEER: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && !busy && a_addr == 6'h00) |=> full_ab[0]); // R2

    AST_RX_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rd && !busy && b_addr == 6'h10 && !(a_wr && a_addr == 6'h00)) |=> !full_ab[0]); // R3

    AST_RING_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && !busy && a_addr == 6'h24 && !a_rstbit && a_req0) |=> pend_ab[0]); // R5

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        a_irq |-> ((~full_ab != 4'h0) || (full_ba != 4'h0) || (pend_ba != 4'h0))); // R7

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= RST_HOLD + 1); // R8

    AST_CLEAN_AFTER_URST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (full_ab == 4'h0 && full_ba == 4'h0 && pend_ab == 4'h0 && pend_ba == 4'h0)); // R9
endmodule

bind msgu_top msgu_chk #(.AW(AW), .RST_HOLD(RST_HOLD)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .a_wr(a_wr), .a_addr(a_addr), .a_req0(a_wdata[19]), .a_rstbit(a_wdata[5]),
    .b_rd(b_rd), .b_addr(b_addr), .a_irq(a_irq),
    .full_ab(full_ab), .full_ba(full_ba), .pend_ab(pend_ab), .pend_ba(pend_ba)
);

// File: tb/sim_msgu_top.sv
`timescale 1ns/1ps
module sim_msgu_top;
    localparam int HOLD = 2;
    localparam logic [5:0] STAT = 6'h20, CTRL = 6'h24;
    localparam logic [31:0] IDLE_ST = 32'h00F0_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [5:0] a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
    logic a_irq, b_irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    msgu_top #(.DW(32), .AW(6), .RST_HOLD(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input bit side, input logic [5:0] ad, input logic [31:0] d);
        @(negedge clk);
        if (!side) begin a_wr = 1; a_addr = ad; a_wdata = d; end
        else       begin b_wr = 1; b_addr = ad; b_wdata = d; end
        @(negedge clk);
        a_wr = 0; b_wr = 0;
    endtask

    task automatic bus_rd(input bit side, input logic [5:0] ad, output logic [31:0] d);
        @(negedge clk);
        if (!side) begin a_rd = 1; a_addr = ad; end
        else       begin b_rd = 1; b_addr = ad; end
        #1 d = side ? b_rdata : a_rdata;
        @(negedge clk);
        a_rd = 0; b_rd = 0;
    endtask

    task automatic peek(input bit side, input logic [5:0] ad, output logic [31:0] d);
        if (!side) a_addr = ad; else b_addr = ad;
        #0.5 d = side ? b_rdata : a_rdata;
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        peek(0, STAT, v); chk("R9 A status after reset", v, IDLE_ST);
        peek(1, STAT, v); chk("R9 B status after reset", v, IDLE_ST);
        peek(0, CTRL, v); chk("R9 A control after reset", v, 0);
        peek(1, CTRL, v); chk("R9 B control after reset", v, 0);
        chk("R7 irq low after reset", {30'd0, a_irq, b_irq}, 0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        peek(0, 6'h28, v); chk("R1 unmapped reads 0", v, 0);
        bus_wr(0, 6'h04, 32'h1234_5678);
        peek(0, 6'h04, v); chk("R1 outgoing slot reads 0", v, 0);
        bus_rd(1, 6'h14, v); chk("R1 incoming slot 1 at 0x14", v, 32'h1234_5678);
    endtask

    task automatic t_a_to_b;
        logic [31:0] v;
        bus_wr(0, 6'h08, 32'hCAFE_0002);
        peek(0, STAT, v); chk("R2 A empty2 cleared", v, 32'h00D0_0000);
        peek(1, STAT, v); chk("R2 B full2 set", v, 32'h02F0_0000);
        bus_rd(1, 6'h18, v); chk("R2 B reads word", v, 32'hCAFE_0002);
        peek(1, STAT, v); chk("R3 B full2 cleared", v, IDLE_ST);
        peek(0, STAT, v); chk("R3 A empty2 restored", v, IDLE_ST);
    endtask

    task automatic t_b_to_a;
        logic [31:0] v;
        bus_wr(1, 6'h00, 32'h0B0B_0000);
        peek(1, STAT, v); chk("R10 B empty0 cleared", v, 32'h0070_0000);
        peek(0, STAT, v); chk("R10 A full0 set", v, 32'h08F0_0000);
        bus_rd(0, 6'h10, v); chk("R10 A reads word", v, 32'h0B0B_0000);
        peek(1, STAT, v); chk("R10 B empty0 restored", v, IDLE_ST);
    endtask

    task automatic t_overwrite;
        logic [31:0] v;
        bus_wr(0, 6'h04, 32'hAAAA_0001);
        bus_wr(0, 6'h04, 32'hBBBB_0001);
        peek(0, STAT, v); chk("R4 A flags unchanged", v, 32'h00B0_0000);
        peek(1, STAT, v); chk("R4 B flags unchanged", v, 32'h04F0_0000);
        bus_rd(1, 6'h14, v); chk("R4 second word held", v, 32'hBBBB_0001);
        bus_rd(1, 6'h14, v); chk("R3 empty read keeps word", v, 32'hBBBB_0001);
        peek(1, STAT, v); chk("R3 empty read keeps flags", v, IDLE_ST);
    endtask

    task automatic t_doorbell;
        logic [31:0] v;
        bus_wr(0, CTRL, 32'h0001_0000);
        peek(1, STAT, v); chk("R5 B pending3 set", v, 32'h10F0_0000);
        peek(0, CTRL, v); chk("R5 A request3 reads 1", v, 32'h0001_0000);
        bus_wr(1, STAT, 32'h0000_0000);
        peek(1, STAT, v); chk("R6 write 0 keeps pending", v, 32'h10F0_0000);
        bus_wr(1, STAT, 32'h1000_0000);
        peek(1, STAT, v); chk("R6 write 1 clears pending", v, IDLE_ST);
        peek(0, CTRL, v); chk("R5 A request3 self-clears", v, 0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        bus_wr(0, CTRL, 32'h0080_0000);
        chk("R7 A irq on empty0", a_irq, 1);
        bus_wr(0, 6'h00, 32'h0000_0011);
        chk("R7 A irq off when full", a_irq, 0);
        bus_rd(1, 6'h10, v);
        chk("R7 A irq back after drain", a_irq, 1);
        bus_wr(0, CTRL, 32'h0);
        chk("R7 A irq off when disabled", a_irq, 0);
        bus_wr(1, CTRL, 32'h0400_0000);
        chk("R7 B irq idle", b_irq, 0);
        bus_wr(0, 6'h04, 32'h0000_0022);
        chk("R7 B irq on full1", b_irq, 1);
        bus_rd(1, 6'h14, v);
        chk("R7 B irq off after read", b_irq, 0);
        bus_wr(1, CTRL, 32'h2000_0000);
        bus_wr(0, CTRL, 32'h0002_0000);
        chk("R7 B irq on pending2", b_irq, 1);
        bus_wr(1, STAT, 32'h2000_0000);
        chk("R7 B irq off after ack", b_irq, 0);
        bus_wr(1, CTRL, 32'h0);
    endtask

    task automatic t_unit_reset;
        logic [31:0] v;
        bus_wr(0, 6'h0C, 32'h0000_0033);
        bus_wr(0, CTRL, 32'h0010_0000);
        bus_wr(1, CTRL, 32'h8000_0000);
        bus_wr(0, CTRL, 32'h0000_0020);
        peek(0, STAT, v); chk("R8 busy visible", v[7], 1);
        peek(1, CTRL, v); chk("R8 control bit5 while busy", v[5], 1);
        bus_wr(1, 6'h00, 32'hDEAD_BEEF);
        peek(0, STAT, v); chk("R8 busy on last cycle", v[7], 1);
        @(negedge clk);
        peek(0, STAT, v); chk("R8 R9 A status after unit reset", v, IDLE_ST);
        peek(1, STAT, v); chk("R9 B status after unit reset", v, IDLE_ST);
        peek(0, CTRL, v); chk("R9 A control cleared", v, 0);
        peek(1, CTRL, v); chk("R9 B control cleared", v, 0);
        bus_rd(1, 6'h1C, v); chk("R9 slot word cleared", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_map();
        t_a_to_b();
        t_b_to_a();
        t_overwrite();
        t_doorbell();
        t_irq();
        t_unit_reset();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule